// File: doc/BRIEF.md
# Byte Lane Sequencer for a 32-bit Data Bus

The block takes one transfer request at a time: a 32-bit byte address, an operand size of one to four bytes and a flag that says the target answers on a 16-bit bus. It produces the bus cycles needed to move the operand. Each cycle has a 30-bit word address, four active-low byte lane enables and an upper-half marker. Address bits 1:0 never leave the block. They only decide which lanes are enabled. Lane enable 0 covers data bits 7:0, enable 1 covers 15:8, enable 2 covers 23:16 and enable 3 covers 31:24. An enable is asserted when it is driven to 0.

An operand that runs past the end of a 32-bit word is split into cycles at consecutive word addresses. The word address wraps from 0x3FFFFFFF to 0 at the top of the 4 GB space. In 16-bit mode, only lanes 0 and 1 carry data. Bytes that belong to lanes 2 and 3 are moved down onto lanes 0 and 1, and `bus_upper` marks that cycle. A word that has bytes in both halves therefore needs two cycles. Each cycle is held on the outputs until the bus acknowledges it. One `req_done` pulse follows the acknowledge of the last cycle. A size of 0 or a size above 4 is rejected with an `req_err` pulse, and no cycle is issued.

Top module: `byte_lane_sequencer`

## Requirements
- R1: The word address of the first cycle equals request address bits 31:2. Each later cycle that moves on to the next word presents that word address plus one, modulo 2^30.
- R2: Full-bus mode (`req_half`=0): enable bit k is 0 exactly for the lanes k in that word that hold operand bytes. Across all cycles of a request, the number of asserted enables equals the operand size.
- R3: Enables are active low. Whenever `bus_valid` is 0, `bus_lanes_n` is 4'b1111.
- R4: In 16-bit mode, every cycle keeps `bus_lanes_n[3:2]` at 2'b11.
- R5: An operand that crosses a word boundary takes cycles at two consecutive word addresses, in ascending order.
- R6: In 16-bit mode, bytes of lanes 2 and 3 are moved onto lanes 0 and 1 with `bus_upper`=1. When a word has bytes in both halves, the lower-half cycle comes first (`bus_upper`=0), then the upper-half cycle.
- R7: `req_done` is a single-cycle pulse in the cycle after the acknowledge of the last cycle. It is never raised earlier.
- R8: A request with size 0 or size greater than 4 raises `req_err` for one cycle in the cycle after `req_start`. It issues no bus cycle.
- R9: `req_start` is ignored while `busy` is 1. The sequence in progress is unchanged and no extra cycle follows it.
- R10: While `bus_valid` is 1 and `bus_ack` is 0, the word address, the enables and `bus_upper` hold their values into the next cycle.
- R11: After reset, `busy`, `bus_valid`, `req_done`, `req_err` and `bus_upper` are 0 and `bus_lanes_n` is 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Request strobe; accepted when `busy` is 0 |
| req_addr | input | 32 | Byte address of the operand |
| req_size | input | 3 | Operand size in bytes; 1 to 4 are valid |
| req_half | input | 1 | Target uses a 16-bit bus for this request |
| bus_ack | input | 1 | The current bus cycle is complete |
| busy | output | 1 | A request is in progress |
| req_done | output | 1 | One-cycle pulse after the final cycle is acknowledged |
| req_err | output | 1 | One-cycle pulse for a rejected size |
| bus_valid | output | 1 | A bus cycle is being presented |
| bus_waddr | output | 30 | Word address of the current cycle |
| bus_lanes_n | output | 4 | Active-low byte lane enables |
| bus_upper | output | 1 | The current cycle carries upper-half bytes moved onto lanes 1:0 |

## Verification
The bench covers every offset and size combination in both bus modes. It compares each cycle with a model that assigns the operand bytes to words and halves one by one.

The corner cases are these:
- Operands at offset 3 of size 2 or 4. A design that ignored the word boundary would issue a single cycle and lose bytes.
- A two-byte operand at address 0xFFFFFFFF. This catches a word address that does not wrap to 0.
- Sixteen-bit requests at offsets 1 and 3. These expose a wrong order of halves, a missing upper marker, or bytes left on lanes 2 and 3.
- Slow acknowledges combined with a second start while busy. These catch outputs that move before the acknowledge and requests that are taken up mid-sequence.
- Sizes 0 and 5. These catch a design that issues a cycle for a request it should reject.

// File: rtl/blsq_pkg.sv
package blsq_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUS  = 1'b1
    } blsq_phase_e;

    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_LANES  = 4;

endpackage

// File: rtl/blsq_mask_gen.sv
module blsq_mask_gen #(
    parameter int unsigned LANES = 4,
    localparam int unsigned OFF_W  = $clog2(LANES),
    localparam int unsigned SIZE_W = OFF_W + 1,
    localparam int unsigned PEND_W = 2 * LANES
) (
    input  logic [OFF_W-1:0]  off_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [PEND_W-1:0] mask_o,
    output logic              ok_o
);

    // Each byte position over two words is covered when it lies in [off, off+size).
    for (genvar i = 0; i < PEND_W; i++) begin : g_pos
        assign mask_o[i] = (int'(off_i) <= i) && (i < int'(off_i) + int'(size_i));
    end

    assign ok_o = (size_i != '0) && (int'(size_i) <= LANES);

endmodule

// File: rtl/blsq_lane_pick.sv
module blsq_lane_pick #(
    parameter int unsigned LANES = 4,
    localparam int unsigned HALF   = LANES / 2,
    localparam int unsigned PEND_W = 2 * LANES
) (
    input  logic [PEND_W-1:0] pend_i,
    input  logic              half_i,
    output logic [LANES-1:0]  lanes_o,
    output logic              upper_o,
    output logic [PEND_W-1:0] rest_o,
    output logic              step_o
);

    logic [LANES-1:0] cur;
    logic [HALF-1:0]  lo_part;
    logic [HALF-1:0]  hi_part;
    logic [LANES-1:0] left;

    always_comb begin
        cur     = pend_i[LANES-1:0];
        lo_part = cur[HALF-1:0];
        hi_part = cur[LANES-1:HALF];
        lanes_o = '0;
        upper_o = 1'b0;
        left    = '0;
        if (!half_i) begin
            lanes_o = cur;
        end else if (lo_part != '0) begin
            lanes_o[HALF-1:0] = lo_part;
            left              = {hi_part, {HALF{1'b0}}};
        end else begin
            lanes_o[HALF-1:0] = hi_part;
            upper_o           = 1'b1;
        end
        // When the current word is exhausted, the next word moves into place.
        if (left == '0) begin
            step_o = 1'b1;
            rest_o = {{LANES{1'b0}}, pend_i[PEND_W-1:LANES]};
        end else begin
            step_o = 1'b0;
            rest_o = {pend_i[PEND_W-1:LANES], left};
        end
    end

endmodule

// File: rtl/byte_lane_sequencer.sv
module byte_lane_sequencer #(
    parameter int unsigned ADDR_W = blsq_pkg::DEF_ADDR_W,
    parameter int unsigned LANES  = blsq_pkg::DEF_LANES,
    localparam int unsigned OFF_W   = $clog2(LANES),
    localparam int unsigned WADDR_W = ADDR_W - OFF_W,
    localparam int unsigned SIZE_W  = OFF_W + 1,
    localparam int unsigned PEND_W  = 2 * LANES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_start,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [SIZE_W-1:0]  req_size,
    input  logic               req_half,
    input  logic               bus_ack,
    output logic               busy,
    output logic               req_done,
    output logic               req_err,
    output logic               bus_valid,
    output logic [WADDR_W-1:0] bus_waddr,
    output logic [LANES-1:0]   bus_lanes_n,
    output logic               bus_upper
);

    import blsq_pkg::*;

    typedef struct packed {
        blsq_phase_e        phase;
        logic [PEND_W-1:0]  pend;
        logic [WADDR_W-1:0] waddr;
        logic               half;
        logic               done;
        logic               err;
    } blsq_state_t;

    blsq_state_t s_d, s_q;

    logic [PEND_W-1:0] new_mask;
    logic              size_ok;
    logic [LANES-1:0]  pick_lanes;
    logic              pick_upper;
    logic [PEND_W-1:0] pick_rest;
    logic              pick_step;

    blsq_mask_gen #(.LANES(LANES)) u_mask (
        .off_i  (req_addr[OFF_W-1:0]),
        .size_i (req_size),
        .mask_o (new_mask),
        .ok_o   (size_ok)
    );

    blsq_lane_pick #(.LANES(LANES)) u_pick (
        .pend_i  (s_q.pend),
        .half_i  (s_q.half),
        .lanes_o (pick_lanes),
        .upper_o (pick_upper),
        .rest_o  (pick_rest),
        .step_o  (pick_step)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (req_start) begin
                    if (size_ok) begin
                        s_d.phase = PH_BUS;
                        s_d.pend  = new_mask;
                        s_d.waddr = req_addr[ADDR_W-1:OFF_W];
                        s_d.half  = req_half;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            PH_BUS: begin
                if (bus_ack) begin
                    s_d.pend = pick_rest;
                    if (pick_step) begin
                        s_d.waddr = s_q.waddr + 1'b1;
                    end
                    if (pick_rest == '0) begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, pend: '0, waddr: '0, half: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_valid   = (s_q.phase == PH_BUS);
    assign busy        = bus_valid;
    assign req_done    = s_q.done;
    assign req_err     = s_q.err;
    assign bus_waddr   = s_q.waddr;
    assign bus_lanes_n = bus_valid ? ~pick_lanes : '1;
    assign bus_upper   = bus_valid & pick_upper;

endmodule

// File: rtl/blsq_checker.sv
module blsq_checker #(
    parameter int unsigned WADDR_W = 30,
    parameter int unsigned LANES   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_ack,
    input logic               busy,
    input logic               req_done,
    input logic               req_err,
    input logic               bus_valid,
    input logic [WADDR_W-1:0] bus_waddr,
    input logic [LANES-1:0]   bus_lanes_n,
    input logic               bus_upper
);

    AST_IDLE_LANES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (bus_lanes_n == '1)); // R3

    AST_CYCLE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_lanes_n != '1)); // R2

    AST_UPPER_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_upper |-> (bus_valid && bus_lanes_n[LANES-1:LANES/2] == '1)); // R6

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_waddr)
                                     && $stable(bus_lanes_n) && $stable(bus_upper))); // R10

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> ($past(bus_valid) && $past(bus_ack) && !bus_valid)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done); // R7

    AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!bus_valid && !busy && !req_done)); // R8

endmodule

bind byte_lane_sequencer blsq_checker #(.WADDR_W(WADDR_W), .LANES(LANES)) u_blsq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_ack     (bus_ack),
    .busy        (busy),
    .req_done    (req_done),
    .req_err     (req_err),
    .bus_valid   (bus_valid),
    .bus_waddr   (bus_waddr),
    .bus_lanes_n (bus_lanes_n),
    .bus_upper   (bus_upper)
);

// File: tb/byte_lane_sequencer_bench.sv
module byte_lane_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic        req_half = 1'b0;
    logic        bus_ack = 1'b0;
    logic        busy, req_done, req_err, bus_valid, bus_upper;
    logic [29:0] bus_waddr;
    logic [3:0]  bus_lanes_n;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [29:0] waddr;
        logic [3:0]  lanes_n;
        logic        upper;
    } cyc_t;

    always #10 clk = ~clk;

    byte_lane_sequencer u_byte_lane_sequencer (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
        .req_size(req_size), .req_half(req_half), .bus_ack(bus_ack),
        .busy(busy), .req_done(req_done), .req_err(req_err), .bus_valid(bus_valid),
        .bus_waddr(bus_waddr), .bus_lanes_n(bus_lanes_n), .bus_upper(bus_upper)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural model: walk the operand byte by byte, grouping by word and half.
    function automatic void build(input logic [31:0] a, input int sz, input bit half,
                                  ref cyc_t q[$]);
        q.delete();
        for (int b = 0; b < sz; b++) begin
            logic [31:0] ba = a + b;
            int  lane = int'(ba[1:0]);
            bit  hi   = half && (lane >= 2);
            cyc_t t;
            if (q.size() == 0 || q[q.size()-1].waddr != ba[31:2] || q[q.size()-1].upper != hi) begin
                t.waddr = ba[31:2]; t.lanes_n = 4'hF; t.upper = hi;
                q.push_back(t);
            end
            t = q[q.size()-1];
            t.lanes_n[half ? lane % 2 : lane] = 1'b0;
            q[q.size()-1] = t;
        end
    endfunction

    task automatic run_req(input logic [31:0] a, input int sz, input bit half,
                           input int delay, input bit probe, input string tag);
        cyc_t q[$];
        int   total_en = 0;
        build(a, (sz >= 1 && sz <= 4) ? sz : 0, half, q);
        @(negedge clk);
        req_start = 1'b1; req_addr = a; req_size = sz[2:0]; req_half = half;
        @(negedge clk);
        req_start = 1'b0; req_addr = ~a; req_size = 3'd1; req_half = ~half;
        if (q.size() == 0) begin
            // R8: rejected size
            chk(req_err === 1'b1 && bus_valid === 1'b0, "R8", {tag, " err pulse"},
                {req_err, bus_valid}, 2'b10);
            @(negedge clk);
            chk(req_err === 1'b0 && bus_valid === 1'b0, "R8", {tag, " no cycle"},
                {req_err, bus_valid}, 2'b00);
            return;
        end
        for (int c = 0; c < q.size(); c++) begin
            for (int w = 0; w <= delay; w++) begin
                chk(bus_valid === 1'b1 && bus_waddr === q[c].waddr, "R1",
                    {tag, " word address"}, {bus_valid, bus_waddr}, {1'b1, q[c].waddr});
                chk(bus_lanes_n === q[c].lanes_n && bus_upper === q[c].upper,
                    half ? "R6" : "R2", {tag, " lanes/upper"},
                    {bus_lanes_n, bus_upper}, {q[c].lanes_n, q[c].upper});
                chk(req_done === 1'b0, "R7", {tag, " early done"}, req_done, 0);
                if (half) chk(bus_lanes_n[3:2] === 2'b11, "R4", {tag, " high lanes idle"},
                              bus_lanes_n, 4'hC);
                if (probe && c == 0 && w == 0) begin
                    req_start = 1'b1; req_addr = 32'h0000_0100; req_size = 3'd4; // R9 probe
                end
                bus_ack = (w == delay);
                @(negedge clk);
                req_start = 1'b0;
                bus_ack = 1'b0;
            end
            total_en += 4 - $countones(q[c].lanes_n);
        end
        chk(total_en == sz, "R2", {tag, " total enables"}, total_en, sz);
        chk(req_done === 1'b1 && bus_valid === 1'b0, "R7", {tag, " done after last ack"},
            {req_done, bus_valid}, 2'b10);
        @(negedge clk);
        chk(req_done === 1'b0 && bus_valid === 1'b0 && bus_lanes_n === 4'hF, "R9",
            {tag, " idle after done"}, {req_done, bus_valid, bus_lanes_n}, 6'b00_1111);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(busy === 1'b0 && bus_valid === 1'b0 && req_done === 1'b0 && req_err === 1'b0
            && bus_upper === 1'b0 && bus_lanes_n === 4'hF, "R11", "reset outputs",
            {busy, bus_valid, req_done, req_err, bus_upper, bus_lanes_n}, 9'h00F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_lanes_n === 4'hF && bus_valid === 1'b0, "R3", "idle lanes high",
            {bus_valid, bus_lanes_n}, 5'h0F);

        run_req(32'h1000_0000, 4, 0, 0, 0, "R2 aligned word");
        run_req(32'h1000_0001, 2, 0, 1, 0, "R2 offset1 size2");
        run_req(32'h2000_0003, 2, 0, 0, 0, "R5 cross size2");
        run_req(32'h2000_0003, 4, 0, 2, 0, "R5 cross size4");
        run_req(32'h2000_0002, 3, 0, 0, 0, "R5 cross size3");
        run_req(32'hFFFF_FFFF, 2, 0, 0, 0, "R1 wrap");
        run_req(32'h3000_0000, 4, 1, 0, 0, "R6 half both");
        run_req(32'h3000_0003, 4, 1, 1, 0, "R6 half three cycles");
        run_req(32'h3000_0002, 2, 1, 0, 0, "R4 upper only");
        run_req(32'h4000_0000, 0, 0, 0, 0, "R8 size0");
        run_req(32'h4000_0000, 5, 1, 0, 0, "R8 size5");
        run_req(32'h5000_0001, 4, 0, 3, 1, "R9 start while busy");
        run_req(32'h5000_0002, 2, 1, 2, 1, "R10 hold in half");
        for (int h = 0; h < 2; h++)
            for (int off = 0; off < 4; off++)
                for (int sz = 1; sz <= 4; sz++)
                    run_req(32'h1234_5670 + off, sz, h[0], (off + sz) % 3, 0, "R5 sweep");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule